// File: doc/BRIEF.md
# Sector Write/Erase Protection Guard

This block decides, for one flash sector request at a time, whether a program or erase may touch that sector. An upstream decoder has already split the target into a one-hot bank number, a one-hot region code and a sector index within that region. The guard looks the sector up in a set of protection words and returns one registered verdict: allowed, refused for protection, or refused for an illegal address. Main-region sectors are covered by a per-sector word and by a per-group word with eight sectors per bit. The non-main, trim and engineering regions each have their own per-sector word. Bit value 1 always means protected.

A request may also ask for the sector after the given one to be checked. A multi-word program whose words cross into the next sector sets this, so that both sectors are cleared before any pulse is applied. A second mode serves bank erase. The protection words then act as a skip mask: a covered sector is reported as needing no further erase pulses, and this is not a protection failure.

Requests and results use valid/ready handshakes. A request is taken when `req_valid` and `req_ready` are both high. Its result is held on the response outputs until `rsp_ready` is seen high with `rsp_valid`. The protection words are plain level inputs, sampled in the cycle the request is accepted.

Top module: `wsg_sector_guard`

## Requirements
- R1: In bank 0 (bank bit 0), main sectors 0 to 31 are protected when bit n of the per-sector word is 1.
- R2: In bank 0, main sectors from 32 upward are protected by group bit k, which covers sectors 8k to 8k+7. Group bits 3:0 have no effect in bank 0.
- R3: In any bank other than bank 0, the per-sector word has no effect. Group bit k protects main sectors 8k to 8k+7, counting from sector 0.
- R4: The region codes are 4'b0001 main, 4'b0010 non-main, 4'b0100 trim and 4'b1000 engineering. In each side region, sector n is protected by bit n of that region's own word.
- R5: A request is illegal if its bank is not one-hot or names a bank at or above NUM_BANKS, if its region is not one of the four codes, or if its sector is at or beyond the region size. The region sizes default to main 256, non-main 4, trim 2 and engineering 2. With a span request, sector+1 must also lie within the region. An illegal request returns fail_addr=1 with fail_prot=0, allow=0 and skip=0.
- R6: In check mode (req_erase_mask=0), a legal request returns fail_prot=1 and allow=0 when its sector is protected. With req_span=1 this also happens when the next sector is protected. Otherwise it returns allow=1. skip is always 0 in this mode.
- R7: In erase-mask mode (req_erase_mask=1), req_span is ignored and fail_prot is never set. A legal request returns skip=1 and allow=0 for a protected sector, and skip=0 and allow=1 otherwise.
- R8: Main sectors whose group index is 28 or higher (sector 224 and above) are never protected by the group word.
- R9: req_ready equals (not rsp_valid) or rsp_ready. rsp_valid rises in the cycle after a request is accepted. While rsp_valid is high and rsp_ready is low, all response outputs hold steady.
- R10: After reset, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Guard can take a request |
| req_bank | input | 5 | One-hot bank number |
| req_region | input | 4 | One-hot region code |
| req_sector | input | SEC_W (9) | Sector index within the region |
| req_span | input | 1 | Also check the following sector |
| req_erase_mask | input | 1 | 1 = bank-erase skip query, 0 = program/erase check |
| prot_direct | input | 32 | Per-sector word for bank-0 main sectors 0..31 |
| prot_group | input | 28 | Per-group word for main sectors, eight per bit |
| prot_nonmain | input | 32 | Per-sector word for the non-main region |
| prot_trim | input | 32 | Per-sector word for the trim region |
| prot_engr | input | 32 | Per-sector word for the engineering region |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_allow | output | 1 | Operation / erase pulse may proceed |
| rsp_fail_prot | output | 1 | Protection violation |
| rsp_fail_addr | output | 1 | Illegal bank, region or sector |
| rsp_skip | output | 1 | Erase-mask mode: sector needs no more pulses |

## Verification
Every verdict is due one cycle after acceptance, because it passes through a single result register. The bench drives a request at a falling edge and drops req_valid at the next falling edge. It compares the response at that same point, after exactly one rising edge. For the stall case, rsp_ready is held low for two cycles with a second request waiting. The bench checks at each falling edge that req_ready stays low and that the first verdict does not change. It then expects the second verdict one cycle after rsp_ready returns high.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int BANK_W         = 5;
  localparam int REGION_W       = 4;
  localparam int SIDE_W         = 32;
  localparam int GROUP_W        = 28;
  localparam int DIRECT_SECTORS = 32;
  localparam int GROUP_SPAN     = 8;

  localparam logic [REGION_W-1:0] REG_MAIN    = 4'b0001;
  localparam logic [REGION_W-1:0] REG_NONMAIN = 4'b0010;
  localparam logic [REGION_W-1:0] REG_TRIM    = 4'b0100;
  localparam logic [REGION_W-1:0] REG_ENGR    = 4'b1000;

  typedef struct packed {
    logic allow;
    logic fail_prot;
    logic fail_addr;
    logic skip;
  } wsg_result_t;
endpackage

// File: rtl/wsg_addr_check.sv
module wsg_addr_check
  import wsg_pkg::*;
#(
  parameter int NUM_BANKS       = 5,
  parameter int MAIN_SECTORS    = 256,
  parameter int NONMAIN_SECTORS = 4,
  parameter int TRIM_SECTORS    = 2,
  parameter int ENGR_SECTORS    = 2,
  parameter int SEC_W           = 9
) (
  input  logic [BANK_W-1:0]   bank,
  input  logic [REGION_W-1:0] region,
  input  logic [SEC_W-1:0]    sector,
  input  logic                span,
  output logic                illegal
);
  localparam int LIM_W = SEC_W + 1;
  localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'((1 << NUM_BANKS) - 1);

  logic             bank_ok;
  logic             region_ok;
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] last;

  always_comb begin
    bank_ok   = (bank != '0) && ((bank & (bank - 1'b1)) == '0) && ((bank & ~BANK_MASK) == '0);
    region_ok = (region != '0) && ((region & (region - 1'b1)) == '0);
    case (region)
      REG_MAIN:    limit = LIM_W'(MAIN_SECTORS);
      REG_NONMAIN: limit = LIM_W'(NONMAIN_SECTORS);
      REG_TRIM:    limit = LIM_W'(TRIM_SECTORS);
      REG_ENGR:    limit = LIM_W'(ENGR_SECTORS);
      default:     limit = '0;
    endcase
    last    = {1'b0, sector} + LIM_W'(span);
    illegal = !bank_ok || !region_ok || (last >= limit);
  end
endmodule

// File: rtl/wsg_prot_lookup.sv
module wsg_prot_lookup
  import wsg_pkg::*;
#(
  parameter int SEC_W = 9
) (
  input  logic                      is_bank0,
  input  logic [REGION_W-1:0]       region,
  input  logic [SEC_W-1:0]          sector,
  input  logic [DIRECT_SECTORS-1:0] direct_word,
  input  logic [GROUP_W-1:0]        group_word,
  input  logic [SIDE_W-1:0]         nonmain_word,
  input  logic [SIDE_W-1:0]         trim_word,
  input  logic [SIDE_W-1:0]         engr_word,
  output logic                      hit
);
  localparam int GRP_SHIFT  = $clog2(GROUP_SPAN);
  localparam int GI_W       = $clog2(GROUP_W);
  localparam int DI_W       = $clog2(DIRECT_SECTORS);
  localparam int SI_W       = $clog2(SIDE_W);
  localparam int BANK0_SKIP = DIRECT_SECTORS / GROUP_SPAN;

  logic [SEC_W-1:0] gidx;
  logic             in_direct;
  logic             grp_usable;
  logic             main_hit;
  logic [SI_W-1:0]  side_idx;

  always_comb begin
    gidx       = sector >> GRP_SHIFT;
    side_idx   = sector[SI_W-1:0];
    in_direct  = is_bank0 && (sector < SEC_W'(DIRECT_SECTORS));
    grp_usable = (gidx < SEC_W'(GROUP_W)) && !(is_bank0 && (gidx < SEC_W'(BANK0_SKIP)));
    if (in_direct)       main_hit = direct_word[sector[DI_W-1:0]];
    else if (grp_usable) main_hit = group_word[gidx[GI_W-1:0]];
    else                 main_hit = 1'b0;
    case (region)
      REG_MAIN:    hit = main_hit;
      REG_NONMAIN: hit = nonmain_word[side_idx];
      REG_TRIM:    hit = trim_word[side_idx];
      REG_ENGR:    hit = engr_word[side_idx];
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/wsg_sector_guard.sv
module wsg_sector_guard
  import wsg_pkg::*;
#(
  parameter int NUM_BANKS       = 5,
  parameter int MAIN_SECTORS    = 256,
  parameter int NONMAIN_SECTORS = 4,
  parameter int TRIM_SECTORS    = 2,
  parameter int ENGR_SECTORS    = 2,
  parameter int SEC_W           = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [REGION_W-1:0]       req_region,
  input  logic [SEC_W-1:0]          req_sector,
  input  logic                      req_span,
  input  logic                      req_erase_mask,
  input  logic [DIRECT_SECTORS-1:0] prot_direct,
  input  logic [GROUP_W-1:0]        prot_group,
  input  logic [SIDE_W-1:0]         prot_nonmain,
  input  logic [SIDE_W-1:0]         prot_trim,
  input  logic [SIDE_W-1:0]         prot_engr,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic                      rsp_allow,
  output logic                      rsp_fail_prot,
  output logic                      rsp_fail_addr,
  output logic                      rsp_skip
);
  localparam int LOOKUPS = 2;

  logic              span_eff;
  logic              addr_bad;
  logic [LOOKUPS-1:0] hit;
  wsg_result_t       verdict;
  wsg_result_t       rsp_q;
  logic              valid_q;

  // erase-mask queries look at one sector only
  assign span_eff = req_span & ~req_erase_mask;

  wsg_addr_check #(
    .NUM_BANKS      (NUM_BANKS),
    .MAIN_SECTORS   (MAIN_SECTORS),
    .NONMAIN_SECTORS(NONMAIN_SECTORS),
    .TRIM_SECTORS   (TRIM_SECTORS),
    .ENGR_SECTORS   (ENGR_SECTORS),
    .SEC_W          (SEC_W)
  ) u_addr (
    .bank   (req_bank),
    .region (req_region),
    .sector (req_sector),
    .span   (span_eff),
    .illegal(addr_bad)
  );

  // one lookup for the addressed sector, one for its successor
  generate
    for (genvar g = 0; g < LOOKUPS; g++) begin : g_look
      logic [SEC_W-1:0] sec_g;
      assign sec_g = req_sector + SEC_W'(g);
      wsg_prot_lookup #(.SEC_W(SEC_W)) u_look (
        .is_bank0    (req_bank[0]),
        .region      (req_region),
        .sector      (sec_g),
        .direct_word (prot_direct),
        .group_word  (prot_group),
        .nonmain_word(prot_nonmain),
        .trim_word   (prot_trim),
        .engr_word   (prot_engr),
        .hit         (hit[g])
      );
    end
  endgenerate

  always_comb begin
    verdict = '0;
    if (addr_bad) begin
      verdict.fail_addr = 1'b1;
    end else if (req_erase_mask) begin
      verdict.skip  = hit[0];
      verdict.allow = ~hit[0];
    end else begin
      verdict.fail_prot = hit[0] | (span_eff & hit[1]);
      verdict.allow     = ~(hit[0] | (span_eff & hit[1]));
    end
  end

  assign req_ready = ~valid_q | rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else if (req_valid && req_ready) begin
      valid_q <= 1'b1;
      rsp_q   <= verdict;
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid     = valid_q;
  assign rsp_allow     = rsp_q.allow;
  assign rsp_fail_prot = rsp_q.fail_prot;
  assign rsp_fail_addr = rsp_q.fail_addr;
  assign rsp_skip      = rsp_q.skip;
endmodule

// File: rtl/wsg_sector_guard_checker.sv
module wsg_sector_guard_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_erase_mask,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic rsp_allow,
  input logic rsp_fail_prot,
  input logic rsp_fail_addr,
  input logic rsp_skip
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid &&
      $stable({rsp_allow, rsp_fail_prot, rsp_fail_addr, rsp_skip})));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_allow, rsp_fail_prot, rsp_fail_addr}));

  assert_skip_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_skip) |-> (!rsp_allow && !rsp_fail_prot && !rsp_fail_addr));

  assert_mask_noprot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_erase_mask) |=> !rsp_fail_prot);

  assert_check_noskip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_erase_mask) |=> !rsp_skip);
endmodule

bind wsg_sector_guard wsg_sector_guard_checker u_wsg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_erase_mask(req_erase_mask),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_allow     (rsp_allow),
  .rsp_fail_prot (rsp_fail_prot),
  .rsp_fail_addr (rsp_fail_addr),
  .rsp_skip      (rsp_skip)
);

// File: tb/test_wsg_sector_guard.sv
module test_wsg_sector_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SEC_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0] req_bank = 5'b00001;
  logic [3:0] req_region = 4'b0001;
  logic [SEC_W-1:0] req_sector = '0;
  logic req_span = 1'b0;
  logic req_erase_mask = 1'b0;
  logic [31:0] prot_direct = '0;
  logic [27:0] prot_group = '0;
  logic [31:0] prot_nonmain = '0;
  logic [31:0] prot_trim = '0;
  logic [31:0] prot_engr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_allow, rsp_fail_prot, rsp_fail_addr, rsp_skip;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsg_sector_guard i_wsg_sector_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_region(req_region), .req_sector(req_sector),
    .req_span(req_span), .req_erase_mask(req_erase_mask),
    .prot_direct(prot_direct), .prot_group(prot_group), .prot_nonmain(prot_nonmain),
    .prot_trim(prot_trim), .prot_engr(prot_engr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_allow(rsp_allow),
    .rsp_fail_prot(rsp_fail_prot), .rsp_fail_addr(rsp_fail_addr), .rsp_skip(rsp_skip)
  );

  // protection of one sector, from the requirement text
  function automatic bit prot_of(input bit b0, input logic [3:0] r, input int s);
    if (r == 4'b0001) begin
      if (b0 && s < 32) return prot_direct[s];
      for (int k = 0; k < 28; k++)
        if (s >= 8*k && s < 8*k + 8 && !(b0 && k < 4)) return prot_group[k];
      return 1'b0;
    end
    if (s >= 32) return 1'b0;
    if (r == 4'b0010) return prot_nonmain[s];
    if (r == 4'b0100) return prot_trim[s];
    if (r == 4'b1000) return prot_engr[s];
    return 1'b0;
  endfunction

  // {allow, fail_prot, fail_addr, skip}
  function automatic logic [3:0] expect_rsp(input logic [4:0] b, input logic [3:0] r,
                                            input int s, input bit span, input bit em);
    int size;
    int last;
    bit p0, p1;
    case (r)
      4'b0001: size = 256;
      4'b0010: size = 4;
      4'b0100: size = 2;
      4'b1000: size = 2;
      default: size = 0;
    endcase
    last = s + ((span && !em) ? 1 : 0);
    if ($countones(b) != 1 || $countones(r) != 1 || last >= size) return 4'b0010;
    p0 = prot_of(b[0], r, s);
    p1 = prot_of(b[0], r, s + 1);
    if (em) return p0 ? 4'b0001 : 4'b1000;
    if (p0 || (span && p1)) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_rsp(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {rsp_allow, rsp_fail_prot, rsp_fail_addr, rsp_skip};
    checks++;
    if (rsp_valid !== 1'b1 || act !== exp) begin
      errors++;
      $display("FAIL %s actual=v%0b/%04b expected=v1/%04b", tag, rsp_valid, act, exp);
    end
  endtask

  task automatic run_req(input string tag, input logic [4:0] b, input logic [3:0] r,
                         input int s, input bit span, input bit em);
    logic [3:0] exp;
    @(negedge clk);
    req_bank = b; req_region = r; req_sector = SEC_W'(s);
    req_span = span; req_erase_mask = em; req_valid = 1'b1;
    exp = expect_rsp(b, r, s, span, em);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R10 rsp_valid in reset", rsp_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R10 rsp_valid after reset", rsp_valid, 1'b0);
    check_bit("R10 req_ready after reset", req_ready, 1'b1);

    // R1: bank 0 direct word
    prot_direct = 32'h0000_0020;
    run_req("R1 bank0 sector5 protected", 5'b00001, 4'b0001, 5, 0, 0);
    run_req("R1 bank0 sector6 free", 5'b00001, 4'b0001, 6, 0, 0);
    check_rsp("R1 literal allow", 4'b1000);

    // R2: low group bits ignored in bank 0
    prot_direct = '0;
    prot_group = 28'h000_001F;
    run_req("R2 bank0 sector20 low group ignored", 5'b00001, 4'b0001, 20, 0, 0);
    check_rsp("R2 literal allow", 4'b1000);
    run_req("R2 bank0 sector32 group4", 5'b00001, 4'b0001, 32, 0, 0);
    run_req("R2 bank0 sector39 group4", 5'b00001, 4'b0001, 39, 0, 0);
    check_rsp("R2 literal prot", 4'b0100);
    run_req("R2 bank0 sector40 group5 free", 5'b00001, 4'b0001, 40, 0, 0);

    // R3: other banks
    prot_direct = 32'hFFFF_FFFF;
    prot_group = 28'h000_0001;
    run_req("R3 bank1 sector3 group0", 5'b00010, 4'b0001, 3, 0, 0);
    check_rsp("R3 literal prot", 4'b0100);
    prot_group = '0;
    run_req("R3 bank4 direct word ignored", 5'b10000, 4'b0001, 3, 0, 0);
    check_rsp("R3 literal allow", 4'b1000);

    // R4: side regions
    prot_nonmain = 32'h4; prot_trim = 32'h2; prot_engr = 32'h1;
    run_req("R4 nonmain sector2", 5'b00001, 4'b0010, 2, 0, 0);
    run_req("R4 nonmain sector1", 5'b00001, 4'b0010, 1, 0, 0);
    run_req("R4 trim sector1", 5'b00100, 4'b0100, 1, 0, 0);
    run_req("R4 engr sector0", 5'b01000, 4'b1000, 0, 0, 0);

    // R5: illegal addresses
    run_req("R5 nonmain sector4 beyond", 5'b00001, 4'b0010, 4, 0, 0);
    check_rsp("R5 literal addr", 4'b0010);
    run_req("R5 bank not onehot", 5'b00011, 4'b0001, 3, 0, 0);
    run_req("R5 bank zero", 5'b00000, 4'b0001, 3, 0, 0);
    run_req("R5 region not onehot", 5'b00001, 4'b0011, 3, 0, 0);
    run_req("R5 span past main end", 5'b00010, 4'b0001, 255, 1, 0);
    check_rsp("R5 literal span addr", 4'b0010);

    // R6: span reaches a protected neighbour
    prot_direct = '0;
    prot_group = 28'h000_0010;
    run_req("R6 span 31 to 32", 5'b00001, 4'b0001, 31, 1, 0);
    check_rsp("R6 literal prot", 4'b0100);
    run_req("R6 no span sector31", 5'b00001, 4'b0001, 31, 0, 0);

    // R7: erase mask
    prot_direct = 32'h0000_0020;
    run_req("R7 mask protected sector", 5'b00001, 4'b0001, 5, 0, 1);
    check_rsp("R7 literal skip", 4'b0001);
    run_req("R7 mask span ignored", 5'b00001, 4'b0001, 31, 1, 1);
    check_rsp("R7 literal allow", 4'b1000);
    run_req("R7 mask span at end legal", 5'b00010, 4'b0001, 255, 1, 1);

    // R8: top sectors beyond the group word
    prot_group = '1;
    run_req("R8 bank1 sector230", 5'b00010, 4'b0001, 230, 0, 0);
    check_rsp("R8 literal allow", 4'b1000);
    run_req("R8 bank1 sector223", 5'b00010, 4'b0001, 223, 0, 0);

    // R9: stall holds the first verdict
    prot_group = '0; prot_direct = 32'h0000_0001;
    @(negedge clk);
    req_bank = 5'b00001; req_region = 4'b0001; req_sector = 0;
    req_span = 0; req_erase_mask = 0; req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_sector = 1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check_bit("R9 req_ready low in stall", req_ready, 1'b0);
      check_rsp("R9 held verdict", 4'b0100);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R9 second verdict", 4'b1000);
    @(negedge clk);
    check_bit("R9 valid drops when idle", rsp_valid, 1'b0);

    // random mix
    void'($urandom(32'h5EC7_0A11));
    for (int n = 0; n < 600; n++) begin
      logic [4:0] b;
      logic [3:0] r;
      int s;
      prot_direct = $urandom; prot_group = 28'($urandom);
      prot_nonmain = $urandom; prot_trim = $urandom; prot_engr = $urandom;
      b = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'(1 << $urandom_range(0, 4));
      r = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'(1 << $urandom_range(0, 3));
      s = (r == 4'b0001) ? $urandom_range(0, 259) : $urandom_range(0, 5);
      run_req("R6 random", b, r, s, 1'($urandom), ($urandom_range(0, 3) == 0));
    end

    finish_run();
  end
endmodule